// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A requester hands it a virtual address together with the kind of access (read or write) and the privilege level (user or supervisor). The walker then reads one entry from the top-level table, and usually one entry from a second-level table. It returns a physical address, a page-fault flag or a protection-fault flag, marked by a one-cycle done strobe.

The top-level table starts at an address held in a table base register, which is loaded through a write strobe. The upper ten bits of the virtual address select a top-level entry. The next ten bits select an entry in the second-level table that the top-level entry names. The low twelve bits are the byte offset inside a 4 KB page. Memory is read through a request port with a valid/ready handshake and a separate response-valid strobe. Each response may arrive after any number of cycles, and the walker waits for it.

Every table entry is 32 bits wide and occupies 4 bytes. Its bits are: bit 0 valid, bit 1 supervisor-only, bit 2 read allowed, bit 3 write allowed, and bits 31:12 hold a page number or table number. A top-level entry whose 32 bits are all zero is null: no page in that 4 MB region exists.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, while resp_done and mem_req_valid are 0.
- R2: A request is taken only in a cycle where req_ready is 1. req_ready stays 0 from the accept until the done strobe. A request presented during that time is ignored and does not change the result of the walk in progress.
- R3: The first memory read of a walk is at table base + vaddr[31:22] * 4. The base is the value last written through base_wr_en before the accept cycle.
- R4: If the top-level entry is all zeros, the walk ends with page fault 1 and protection fault 0, after exactly one memory read.
- R5: For a non-null top-level entry, the second read is at {entry[31:12], 12'h000} + vaddr[21:12] * 4. This holds even when the entry's bit 0 is clear. A walk makes at most two reads.
- R6: If bit 0 of the second-level entry is 0, the walk ends with page fault 1, protection fault 0 and physical address 0.
- R7: On success, the physical address is {entry[31:12], vaddr[11:0]} and both fault flags are 0.
- R8: A valid entry with bit 1 set, accessed with req_user = 1, gives protection fault 1 and physical address 0.
- R9: A valid entry gives protection fault 1 for a read (req_write = 0) when bit 2 is 0, and for a write (req_write = 1) when bit 3 is 0.
- R10: The two faults are never reported together. An invalid final entry reports only the page fault, whatever its permission bits say.
- R11: mem_req_valid stays 1 with an unchanged address until mem_req_ready is 1. Any stall on the request side and any delay of the response give the same result.
- R12: resp_done is high for exactly one cycle, and req_ready is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Load the table base register |
| base_wr_data | input | 32 | New table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| resp_done | output | 1 | One-cycle result strobe |
| resp_paddr | output | 32 | Physical address (0 on a fault) |
| resp_page_fault | output | 1 | Translation missing |
| resp_prot_fault | output | 1 | Permission violated |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | 32 | Entry read from memory |

## Verification
The assertions check these on every cycle: the request is held steady while stalled, the done strobe is one cycle long, the walker is busy while a memory request is open, no walk makes more than two reads, a walk that stops after one read is a page fault, the two faults never appear together, and a successful translation keeps the page offset. Only the bench scenarios can show the address arithmetic itself: that the right top-level and second-level entries are read for a given base and virtual address, the result of each permission combination, that a base change is used by later walks, and that a request made while busy is ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_e;

  localparam int FLD_VALID = 0;
  localparam int FLD_SUP   = 1;
  localparam int FLD_RD    = 2;
  localparam int FLD_WR    = 3;
  localparam int FLD_NUM   = 4;
endpackage

// File: rtl/pt_walker_split.sv
module pt_walker_split #(
  parameter int VA_W  = 32,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [L1_W-1:0]  l1_idx,
  output logic [L2_W-1:0]  l2_idx,
  output logic [OFF_W-1:0] offset
);
  localparam int L2_LO = OFF_W;
  localparam int L1_LO = OFF_W + L2_W;

  always_comb begin
    offset = vaddr[OFF_W-1:0];
    l2_idx = vaddr[L2_LO +: L2_W];
    l1_idx = vaddr[L1_LO +: L1_W];
  end
endmodule

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int PA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int ENT_LOG2  = 2
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int PAD_W = PA_W - IDX_W - ENT_LOG2;

  logic [PA_W-1:0] scaled;

  always_comb begin
    scaled     = {{PAD_W{1'b0}}, index, {ENT_LOG2{1'b0}}};
    entry_addr = table_base + scaled;
  end
endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [FLD_NUM-1:0] flags,
  input  logic               is_write,
  input  logic               is_user,
  output logic               page_fault,
  output logic               prot_fault
);
  logic deny_priv;
  logic deny_rw;

  always_comb begin
    deny_priv  = flags[FLD_SUP] & is_user;
    deny_rw    = is_write ? ~flags[FLD_WR] : ~flags[FLD_RD];
    page_fault = ~flags[FLD_VALID];
    prot_fault = flags[FLD_VALID] & (deny_priv | deny_rw);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_wr_en,
  input  logic [ENT_W-1:0] base_wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             resp_done,
  output logic [ENT_W-1:0] resp_paddr,
  output logic             resp_page_fault,
  output logic             resp_prot_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [ENT_W-1:0] mem_req_addr,
  input  logic             mem_resp_valid,
  input  logic [ENT_W-1:0] mem_resp_data
);
  localparam int PA_W     = ENT_W;
  localparam int PN_W     = ENT_W - OFF_W;
  localparam int ENT_LOG2 = $clog2(ENT_W / 8);

  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic             user_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  addr_q;
  logic             done_q;
  logic             pf_q;
  logic             prot_q;
  logic [PA_W-1:0]  paddr_q;

  logic [VA_W-1:0]  va_sel;
  logic [L1_W-1:0]  l1_idx;
  logic [L2_W-1:0]  l2_idx;
  logic [OFF_W-1:0] pg_off;
  logic [PA_W-1:0]  l1_addr;
  logic [PA_W-1:0]  l2_base;
  logic [PA_W-1:0]  l2_addr;
  logic             chk_pf;
  logic             chk_prot;
  logic             l1_null;

  assign va_sel  = (state_q == ST_IDLE) ? req_vaddr : va_q;
  assign l2_base = {mem_resp_data[ENT_W-1 -: PN_W], {OFF_W{1'b0}}};
  assign l1_null = (mem_resp_data == '0);

  pt_walker_split #(
    .VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)
  ) u_split (
    .vaddr(va_sel), .l1_idx(l1_idx), .l2_idx(l2_idx), .offset(pg_off)
  );

  pt_walker_addr #(
    .PA_W(PA_W), .IDX_W(L1_W), .ENT_LOG2(ENT_LOG2)
  ) u_l1_addr (
    .table_base(base_q), .index(l1_idx), .entry_addr(l1_addr)
  );

  pt_walker_addr #(
    .PA_W(PA_W), .IDX_W(L2_W), .ENT_LOG2(ENT_LOG2)
  ) u_l2_addr (
    .table_base(l2_base), .index(l2_idx), .entry_addr(l2_addr)
  );

  pt_walker_perm u_perm (
    .flags(mem_resp_data[FLD_NUM-1:0]),
    .is_write(wr_q),
    .is_user(user_q),
    .page_fault(chk_pf),
    .prot_fault(chk_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      pf_q    <= 1'b0;
      prot_q  <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (base_wr_en) begin
        base_q <= base_wr_data;
      end
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            user_q  <= req_user;
            addr_q  <= l1_addr;
            state_q <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: begin
          if (mem_req_ready) state_q <= ST_L1_WAIT;
        end
        ST_L1_WAIT: begin
          if (mem_resp_valid) begin
            if (l1_null) begin
              pf_q    <= 1'b1;
              prot_q  <= 1'b0;
              paddr_q <= '0;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              addr_q  <= l2_addr;
              state_q <= ST_L2_REQ;
            end
          end
        end
        ST_L2_REQ: begin
          if (mem_req_ready) state_q <= ST_L2_WAIT;
        end
        ST_L2_WAIT: begin
          if (mem_resp_valid) begin
            pf_q    <= chk_pf;
            prot_q  <= chk_prot;
            paddr_q <= (chk_pf | chk_prot) ? '0
                       : {mem_resp_data[ENT_W-1 -: PN_W], pg_off};
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign mem_req_valid   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr    = addr_q;
  assign resp_done       = done_q;
  assign resp_paddr      = paddr_q;
  assign resp_page_fault = pf_q;
  assign resp_prot_fault = prot_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             resp_done,
  input logic [ENT_W-1:0] resp_paddr,
  input logic             resp_page_fault,
  input logic             resp_prot_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [ENT_W-1:0] mem_req_addr
);
  logic [OFF_W-1:0] off_cap;
  logic [1:0]       n_reads;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_cap <= '0;
      n_reads <= '0;
    end else if (req_valid && req_ready) begin
      off_cap <= req_vaddr[OFF_W-1:0];
      n_reads <= '0;
    end else if (mem_req_valid && mem_req_ready && n_reads != 2'd3) begin
      n_reads <= n_reads + 2'd1;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_single_read_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_done && n_reads == 2'd1) |-> (resp_page_fault && !resp_prot_fault));

  p_two_reads_max_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (n_reads < 2'd2));

  p_fault_zero_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (resp_done && resp_page_fault) |-> (resp_paddr == '0));

  p_offset_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (resp_done && !resp_page_fault && !resp_prot_fault)
      |-> (resp_paddr[OFF_W-1:0] == off_cap));

  p_fault_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> !(resp_page_fault && resp_prot_fault));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> (!resp_done && req_ready));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_vaddr(req_vaddr),
  .resp_done(resp_done),
  .resp_paddr(resp_paddr),
  .resp_page_fault(resp_page_fault),
  .resp_prot_fault(resp_prot_fault),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        resp_done;
  logic [31:0] resp_paddr;
  logic        resp_page_fault;
  logic        resp_prot_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] mem [logic [31:0]];
  int          stall_cfg = 0;
  int          lat_cfg   = 0;
  int          stall_cnt = 0;
  int          lat_cnt   = 0;
  bit          pending   = 1'b0;
  logic [31:0] pend_data = '0;
  int          n_reads   = 0;
  int          stall_seen = 0;
  logic [31:0] rd_addr [0:3];

  pt_walker uut (
    .clk(clk), .rst(rst),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .resp_done(resp_done), .resp_paddr(resp_paddr),
    .resp_page_fault(resp_page_fault), .resp_prot_fault(resp_prot_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model: decides at falling edges, handshakes happen at rising edges
  initial begin
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (pending) begin
        if (lat_cnt == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = pend_data;
          pending        = 1'b0;
        end else begin
          lat_cnt--;
        end
      end
      mem_req_ready = 1'b0;
      if (mem_req_valid && !pending && !mem_resp_valid) begin
        if (stall_cnt == 0) begin
          mem_req_ready = 1'b1;
          if (n_reads < 4) rd_addr[n_reads] = mem_req_addr;
          n_reads++;
          pend_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
          pending   = 1'b1;
          lat_cnt   = lat_cfg;
          stall_cnt = stall_cfg;
        end else begin
          stall_cnt--;
          stall_seen++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en   = 1'b1;
    base_wr_data = b;
    @(negedge clk);
    base_wr_en   = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                      input int noise, output logic [31:0] pa,
                      output bit pf, output bit pr);
    int guard;
    @(negedge clk);
    n_reads    = 0;
    stall_seen = 0;
    stall_cnt  = stall_cfg;
    req_vaddr  = va;
    req_write  = wr;
    req_user   = usr;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < noise; i++) begin
      req_valid = 1'b1;
      req_vaddr = ~va;
      req_write = ~wr;
      chk(req_ready == 1'b0, "R2 busy ready", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (!resp_done && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    chk(resp_done == 1'b1, "R12 done seen", {31'b0, resp_done}, 32'h1);
    pa = resp_paddr;
    pf = resp_page_fault;
    pr = resp_prot_fault;
    @(negedge clk);
    chk(resp_done == 1'b0 && req_ready == 1'b1, "R12 pulse then idle",
        {30'b0, resp_done, req_ready}, 32'h1);
  endtask

  task automatic expect_res(input string tag, input logic [31:0] pa,
                            input bit pf, input bit pr, input logic [31:0] epa,
                            input bit epf, input bit epr);
    chk(pa == epa, tag, pa, epa);
    chk(pf == epf && pr == epr, tag, {30'b0, pf, pr}, {30'b0, epf, epr});
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1 && resp_done == 1'b0 && mem_req_valid == 1'b0,
        "R1 reset state", {29'b0, req_ready, resp_done, mem_req_valid}, 32'h4);
  endtask

  task automatic t_success();
    logic [31:0] pa; bit pf, pr;
    walk(32'h0040_2345, 1'b0, 1'b0, 0, pa, pf, pr);
    expect_res("R7 supervisor read", pa, pf, pr, 32'hABCD_E345, 1'b0, 1'b0);
    chk(n_reads == 2, "R5 read count", n_reads, 2);
    chk(rd_addr[0] == 32'h0001_0004, "R3 first address", rd_addr[0], 32'h0001_0004);
    chk(rd_addr[1] == 32'h0002_0008, "R5 second address", rd_addr[1], 32'h0002_0008);
    walk(32'h0040_2FFF, 1'b1, 1'b0, 0, pa, pf, pr);
    expect_res("R7 supervisor write", pa, pf, pr, 32'hABCD_EFFF, 1'b0, 1'b0);
  endtask

  task automatic t_priv();
    logic [31:0] pa; bit pf, pr;
    walk(32'h0040_2345, 1'b0, 1'b1, 0, pa, pf, pr);
    expect_res("R8 user on supervisor page", pa, pf, pr, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_rw();
    logic [31:0] pa; bit pf, pr;
    walk(32'h0040_3010, 1'b0, 1'b1, 0, pa, pf, pr);
    expect_res("R9 read allowed", pa, pf, pr, 32'h1234_5010, 1'b0, 1'b0);
    walk(32'h0040_3010, 1'b1, 1'b1, 0, pa, pf, pr);
    expect_res("R9 write denied", pa, pf, pr, 32'h0, 1'b0, 1'b1);
    walk(32'h0040_6020, 1'b0, 1'b0, 0, pa, pf, pr);
    expect_res("R9 read denied", pa, pf, pr, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_invalid();
    logic [31:0] pa; bit pf, pr;
    walk(32'h0040_4000, 1'b0, 1'b0, 0, pa, pf, pr);
    expect_res("R6 invalid final entry", pa, pf, pr, 32'h0, 1'b1, 1'b0);
    walk(32'h0040_5ABC, 1'b1, 1'b1, 0, pa, pf, pr);
    expect_res("R10 page fault wins", pa, pf, pr, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_null();
    logic [31:0] pa; bit pf, pr;
    walk(32'h01C0_2345, 1'b0, 1'b0, 0, pa, pf, pr);
    expect_res("R4 null top entry", pa, pf, pr, 32'h0, 1'b1, 1'b0);
    chk(n_reads == 1, "R4 single read", n_reads, 1);
    chk(rd_addr[0] == 32'h0001_001C, "R3 null index address", rd_addr[0], 32'h0001_001C);
  endtask

  task automatic t_base();
    logic [31:0] pa; bit pf, pr;
    set_base(32'h0003_0000);
    walk(32'h0040_2345, 1'b0, 1'b1, 0, pa, pf, pr);
    expect_res("R3 new base result", pa, pf, pr, 32'h5555_5345, 1'b0, 1'b0);
    chk(rd_addr[0] == 32'h0003_0004, "R3 new base address", rd_addr[0], 32'h0003_0004);
    chk(rd_addr[1] == 32'h0004_0008, "R5 top valid bit clear", rd_addr[1], 32'h0004_0008);
    set_base(32'h0001_0000);
  endtask

  task automatic t_latency();
    logic [31:0] pa; bit pf, pr;
    stall_cfg = 3;
    lat_cfg   = 5;
    walk(32'h0040_2345, 1'b0, 1'b0, 0, pa, pf, pr);
    expect_res("R11 slow memory", pa, pf, pr, 32'hABCD_E345, 1'b0, 1'b0);
    chk(stall_seen == 6, "R11 stall cycles", stall_seen, 6);
    stall_cfg = 0;
    lat_cfg   = 0;
  endtask

  task automatic t_busy();
    logic [31:0] pa; bit pf, pr;
    lat_cfg = 4;
    walk(32'h0040_3123, 1'b0, 1'b0, 3, pa, pf, pr);
    expect_res("R2 busy request ignored", pa, pf, pr, 32'h1234_5123, 1'b0, 1'b0);
    chk(n_reads == 2, "R2 no extra reads", n_reads, 2);
    lat_cfg = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_0008] = 32'hABCD_E00F;
    mem[32'h0002_000C] = 32'h1234_5005;
    mem[32'h0002_0010] = 32'h0000_000E;
    mem[32'h0002_0014] = 32'h0000_0000;
    mem[32'h0002_0018] = 32'h7777_7009;
    mem[32'h0003_0004] = 32'h0004_0000;
    mem[32'h0004_0008] = 32'h5555_5005;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    set_base(32'h0001_0000);
    t_success();
    t_priv();
    t_rw();
    t_invalid();
    t_null();
    t_base();
    t_latency();
    t_busy();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule